// File: doc/BRIEF.md
# State-Space Trajectory Predictor

This block projects a small discrete linear plant model forward in time and turns every projected output into a handful of Boolean flags. A start pulse loads the measured state and the input vector. The block then holds that input constant and runs the model for a chosen number of steps. For each step it forms the next state from the current state and the input. It then forms the output vector from the new state and the input, and compares the absolute value of selected outputs against thresholds. One model step stands for one control period, for example 0.1 s at a 10 Hz update rate.

All arithmetic is signed Q8.8. A single multiply-accumulate unit does the work, one product term per clock. It is stepped through the state rows and then the output rows by a small sequencer. Each step produces one strobe carrying the step number, the output vector and the flag bits. A downstream temporal-logic monitor can therefore consume the predicted trace exactly like a live one. A done flag marks the end of the horizon.

Top module: `ssp_predictor`

## Requirements
- R1: After reset, valid_o and done_o are low, and step_o and y_o are zero.
- R2: Each step, the next state is x'(i) = sum over j of A(i,j)·x(j) + sum over m of B(i,m)·u(m). Coefficient A(i,j) sits at element i·NX+j of a_coef_i. B(i,m) sits at element i·NU+m of b_coef_i. Each element is W bits wide, element 0 in the lowest bits.
- R3: The output vector is y(i) = sum of C(i,j)·x'(j) + sum of D(i,m)·u(m), using the state just computed. C and D follow the row-major layout of R2. y(i) sits at element i of y_o while valid_o is high.
- R4: valid_o is a one-cycle pulse, produced once per step. step_o counts 1, 2, … P across the pulses. The first pulse comes (NX+NY)·(NX+NU) clocks after the accepting start edge, which is 12 clocks for the defaults, and the pulses keep that spacing.
- R5: done_o rises in the same cycle as the pulse for step P. It stays high with no further pulses until a start is accepted, and it is low in the cycle after that start.
- R6: A start with horizon 0 sets done_o in the next cycle and produces no valid pulse.
- R7: A start pulse while a prediction is running is ignored. The trace continues from the originally captured state.
- R8: Flag k is the comparison of |y(sel k)| with the unsigned threshold k. Mode bit 0 means the flag is set when the magnitude is strictly less than the threshold. Mode bit 1 means it is set when the magnitude is strictly greater. The magnitude of -32768 counts as 32768.
- R9: Each accumulated sum is rounded by adding 2^(FRAC-1) and shifting right arithmetically by FRAC. It is then saturated to the range -32768 to 32767.
- R10: The input vector is captured at the accepted start. Changes on u_i afterwards have no effect on the running trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | start request; accepted only when idle or done |
| horizon_i | input | HW | number of steps P |
| x0_i | input | NX·W | initial state |
| u_i | input | NU·W | input vector, held for the horizon |
| a_coef_i | input | NX·NX·W | state matrix, row-major |
| b_coef_i | input | NX·NU·W | input matrix, row-major |
| c_coef_i | input | NY·NX·W | output matrix, row-major |
| d_coef_i | input | NY·NU·W | feedthrough matrix, row-major |
| thr_i | input | NP·W | unsigned magnitude threshold per flag |
| mode_i | input | NP | 0: less-than, 1: greater-than |
| sel_i | input | NP·SW | output element read by each flag |
| valid_o | output | 1 | one pulse per predicted step |
| step_o | output | HW | step number of the current pulse |
| y_o | output | NY·W | predicted output vector |
| prop_o | output | NP | flag bits |
| done_o | output | 1 | horizon finished |

## Verification
A table of four coefficient sets is run against a bench model of the recurrence. The first set is a point-mass integrator with identity output, which exposes the state directly. The second mixes signs and uses a non-trivial C and D, which separates the state from the output path and catches errors in rounding direction. The third drives values that grow past the 16-bit range, so a missing clamp or a wrong magnitude of -32768 shows up. The fourth is a single-step horizon. A restart pulse is injected during one run and an input change during another, to show that the captured values govern the trace. Directed cases cover reset, a zero horizon, the hold of the done flag and its clearing on restart.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_STATE = 2'd1,
    PH_OUT   = 2'd2,
    PH_DONE  = 2'd3
  } ph_e;
endpackage

// File: rtl/ssp_mac.sv
module ssp_mac #(
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int NT   = 3,
  localparam int AW  = 2*W + $clog2(NT+1) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  input  logic signed [W-1:0] a_i,
  input  logic signed [W-1:0] b_i,
  output logic signed [W-1:0] res_o
);
  localparam logic signed [AW-1:0] MAXV = AW'((64'sd1 <<< (W-1)) - 64'sd1);
  localparam logic signed [AW-1:0] MINV = -MAXV - AW'(1);
  localparam logic signed [AW-1:0] HALF = AW'(1) << (FRAC-1);

  logic signed [2*W-1:0] prod;
  logic signed [AW-1:0]  acc_q, acc_nxt, rnd, shr;

  assign prod    = a_i * b_i;
  assign acc_nxt = (clr_i ? '0 : acc_q) + AW'(prod);
  assign rnd     = acc_nxt + HALF;
  assign shr     = rnd >>> FRAC;

  always_comb begin
    if (shr > MAXV)      res_o = MAXV[W-1:0];
    else if (shr < MINV) res_o = MINV[W-1:0];
    else                 res_o = shr[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
#(
  parameter int NX = 2,
  parameter int NU = 1,
  parameter int NY = 2,
  parameter int HW = 8,
  localparam int NT = NX + NU,
  localparam int NR = (NX > NY) ? NX : NY,
  localparam int RW = (NR > 1) ? $clog2(NR) : 1,
  localparam int CW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [HW-1:0] hz_i,
  output logic          accept_o,
  output ph_e           ph_o,
  output logic [RW-1:0] row_o,
  output logic [CW-1:0] col_o,
  output logic [HW-1:0] step_o,
  output logic          run_o,
  output logic          term_last_o,
  output logic          state_end_o,
  output logic          step_end_o
);
  ph_e           ph_q;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;
  logic [HW-1:0] step_q, hz_q;
  logic          row_last;

  assign run_o       = (ph_q == PH_STATE) || (ph_q == PH_OUT);
  assign accept_o    = start_i && !run_o;
  assign row_last    = (ph_q == PH_STATE) ? (row_q == RW'(NX-1)) : (row_q == RW'(NY-1));
  assign term_last_o = run_o && (col_q == CW'(NT-1));
  assign state_end_o = term_last_o && (ph_q == PH_STATE) && row_last;
  assign step_end_o  = term_last_o && (ph_q == PH_OUT) && row_last;
  assign ph_o   = ph_q;
  assign row_o  = row_q;
  assign col_o  = col_q;
  assign step_o = step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      row_q  <= '0;
      col_q  <= '0;
      step_q <= '0;
      hz_q   <= '0;
    end else if (accept_o) begin
      hz_q   <= hz_i;
      step_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
      ph_q   <= (hz_i == '0) ? PH_DONE : PH_STATE;
    end else if (run_o) begin
      if (col_q == CW'(NT-1)) begin
        col_q <= '0;
        if (row_last) begin
          row_q <= '0;
          if (ph_q == PH_STATE) begin
            ph_q <= PH_OUT;
          end else begin
            step_q <= step_q + HW'(1);
            ph_q   <= (step_q + HW'(1) == hz_q) ? PH_DONE : PH_STATE;
          end
        end else begin
          row_q <= row_q + RW'(1);
        end
      end else begin
        col_q <= col_q + CW'(1);
      end
    end
  end

  assert_step_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> (step_q < hz_q));
endmodule

// File: rtl/ssp_prop.sv
module ssp_prop #(
  parameter int W  = 16,
  parameter int NY = 2,
  localparam int SW = (NY > 1) ? $clog2(NY) : 1
) (
  input  logic [NY*W-1:0] y_i,
  input  logic [SW-1:0]   sel_i,
  input  logic            mode_i,
  input  logic [W-1:0]    thr_i,
  output logic            hit_o
);
  logic [W-1:0] v;
  logic [W:0]   ext, mag;

  always_comb begin
    int s;
    s = int'(sel_i);
    if (s >= NY) s = 0;
    v   = y_i[s*W +: W];
    ext = {v[W-1], v};
    mag = ext[W] ? (~ext + 1'b1) : ext;
    hit_o = mode_i ? (mag > {1'b0, thr_i}) : (mag < {1'b0, thr_i});
  end
endmodule

// File: rtl/ssp_predictor.sv
module ssp_predictor
  import ssp_pkg::*;
#(
  parameter int NX   = 2,
  parameter int NU   = 1,
  parameter int NY   = 2,
  parameter int NP   = 4,
  parameter int W    = 16,
  parameter int FRAC = 8,
  parameter int HW   = 8,
  localparam int SW  = (NY > 1) ? $clog2(NY) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [HW-1:0]      horizon_i,
  input  logic [NX*W-1:0]    x0_i,
  input  logic [NU*W-1:0]    u_i,
  input  logic [NX*NX*W-1:0] a_coef_i,
  input  logic [NX*NU*W-1:0] b_coef_i,
  input  logic [NY*NX*W-1:0] c_coef_i,
  input  logic [NY*NU*W-1:0] d_coef_i,
  input  logic [NP*W-1:0]    thr_i,
  input  logic [NP-1:0]      mode_i,
  input  logic [NP*SW-1:0]   sel_i,
  output logic               valid_o,
  output logic [HW-1:0]      step_o,
  output logic [NY*W-1:0]    y_o,
  output logic [NP-1:0]      prop_o,
  output logic               done_o
);
  localparam int NT = NX + NU;
  localparam int NR = (NX > NY) ? NX : NY;
  localparam int RW = (NR > 1) ? $clog2(NR) : 1;
  localparam int CW = (NT > 1) ? $clog2(NT) : 1;

  ph_e           ph;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [HW-1:0] step_cnt;
  logic          accept, run, term_last, state_end, step_end;

  logic [NX*W-1:0] x_q, xn_q;
  logic [NU*W-1:0] u_q;
  logic [NY*W-1:0] y_q;
  logic            valid_q;
  logic [HW-1:0]   step_q;

  logic signed [W-1:0] coef, vec, res;

  ssp_seq #(.NX(NX), .NU(NU), .NY(NY), .HW(HW)) u_seq (
    .clk_i, .rst_ni, .start_i, .hz_i(horizon_i),
    .accept_o(accept), .ph_o(ph), .row_o(row), .col_o(col), .step_o(step_cnt),
    .run_o(run), .term_last_o(term_last), .state_end_o(state_end), .step_end_o(step_end)
  );

  // operand select: columns below NX read the state, the rest the input
  always_comb begin
    int r, c, m;
    r = int'(row);
    c = int'(col);
    m = (c >= NX) ? (c - NX) : 0;
    if (c < NX) vec = x_q[c*W +: W];
    else        vec = u_q[m*W +: W];
    if (ph == PH_OUT) begin
      if (c < NX) coef = c_coef_i[(r*NX + c)*W +: W];
      else        coef = d_coef_i[(r*NU + m)*W +: W];
    end else begin
      if (r >= NX) r = 0;
      if (c < NX) coef = a_coef_i[(r*NX + c)*W +: W];
      else        coef = b_coef_i[(r*NU + m)*W +: W];
    end
  end

  ssp_mac #(.W(W), .FRAC(FRAC), .NT(NT)) u_mac (
    .clk_i, .rst_ni, .en_i(run), .clr_i(col == '0),
    .a_i(coef), .b_i(vec), .res_o(res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      xn_q    <= '0;
      u_q     <= '0;
      y_q     <= '0;
      valid_q <= 1'b0;
      step_q  <= '0;
    end else if (accept) begin
      x_q     <= x0_i;
      u_q     <= u_i;
      valid_q <= 1'b0;
    end else begin
      valid_q <= step_end;
      if (step_end) step_q <= step_cnt + HW'(1);
      if (term_last && ph == PH_STATE) begin
        if (state_end) begin
          x_q <= xn_q;
          x_q[int'(row)*W +: W] <= res;
        end else begin
          xn_q[int'(row)*W +: W] <= res;
        end
      end
      if (term_last && ph == PH_OUT) y_q[int'(row)*W +: W] <= res;
    end
  end

  for (genvar k = 0; k < NP; k++) begin : g_prop
    ssp_prop #(.W(W), .NY(NY)) u_prop (
      .y_i(y_q), .sel_i(sel_i[k*SW +: SW]), .mode_i(mode_i[k]),
      .thr_i(thr_i[k*W +: W]), .hit_o(prop_o[k])
    );
  end

  assign valid_o = valid_q;
  assign step_o  = step_q;
  assign y_o     = y_q;
  assign done_o  = (ph == PH_DONE);

  assert_valid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  assert_valid_step_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (step_o != '0));
  assert_done_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  assert_no_emit_after_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> !valid_o);
  assert_busy_start_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start_i) |=> $stable(u_q));
endmodule

// File: tb/sim_ssp_predictor.sv
`timescale 1ns/1ps
module sim_ssp_predictor;
  localparam int W = 16, NX = 2, NU = 1, NY = 2, NP = 4, HW = 8, SW = 1;
  localparam int STEP_CYC = (NX + NY) * (NX + NU);

  typedef struct packed {
    logic [7:0]  hz;
    logic [15:0] x0, x1, u, a00, a01, a10, a11, b0, b1, c00, c01, c10, c11, d0, d1;
  } vec_t;

  // stimulus table; expected traces come from the bench model below
  localparam vec_t VECS [4] = '{
    '{8'd5, 16'd0, 16'd0, 16'd64, 16'd256, 16'd26, 16'd0, 16'd256,
      16'd1, 16'd26, 16'd256, 16'd0, 16'd0, 16'd256, 16'd0, 16'd0},
    '{8'd4, -16'sd500, 16'd333, -16'sd120, 16'd230, -16'sd40, 16'd50, 16'd200,
      -16'sd30, 16'd77, 16'd128, -16'sd256, 16'd300, 16'd17, 16'd5, -16'sd9},
    '{8'd3, 16'd20000, -16'sd20000, 16'd0, 16'd600, 16'd0, 16'd0, -16'sd600,
      16'd0, 16'd0, 16'd256, 16'd0, 16'd0, 16'd256, 16'd0, 16'd0},
    '{8'd1, 16'd300, -16'sd700, 16'd1000, 16'd100, 16'd200, -16'sd300, -16'sd50,
      16'd12, -16'sd7, -16'sd256, 16'd128, 16'd64, 16'd90, 16'd3, 16'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [HW-1:0] horizon = '0;
  logic [NX*W-1:0] x0 = '0;
  logic [NU*W-1:0] u = '0;
  logic [NX*NX*W-1:0] a_c = '0;
  logic [NX*NU*W-1:0] b_c = '0;
  logic [NY*NX*W-1:0] c_c = '0;
  logic [NY*NU*W-1:0] d_c = '0;
  logic [NP*W-1:0] thr;
  logic [NP-1:0] mode;
  logic [NP*SW-1:0] sel;
  logic valid, done;
  logic [HW-1:0] step;
  logic [NY*W-1:0] y;
  logic [NP-1:0] prop;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  // flag config: 0:|y0|<26  1:|y1|>154  2:|y0|>256  3:|y1|<2000
  assign thr  = {16'd2000, 16'd256, 16'd154, 16'd26};
  assign mode = 4'b0110;
  assign sel  = 4'b1010;

  ssp_predictor u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .horizon_i(horizon),
    .x0_i(x0), .u_i(u), .a_coef_i(a_c), .b_coef_i(b_c), .c_coef_i(c_c), .d_coef_i(d_c),
    .thr_i(thr), .mode_i(mode), .sel_i(sel),
    .valid_o(valid), .step_o(step), .y_o(y), .prop_o(prop), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rs(input longint acc);
    longint r;
    r = (acc + 128) >>> 8;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  function automatic int sx(input logic [15:0] v);
    return int'($signed(v));
  endfunction

  function automatic bit pbit(input int v, input int t, input bit md);
    int mg;
    mg = (v < 0) ? -v : v;
    return md ? (mg > t) : (mg < t);
  endfunction

  task automatic fire(input vec_t v);
    @(negedge clk);
    horizon = v.hz;
    x0  = {v.x1, v.x0};
    u   = v.u;
    a_c = {v.a11, v.a10, v.a01, v.a00};
    b_c = {v.b1, v.b0};
    c_c = {v.c11, v.c10, v.c01, v.c00};
    d_c = {v.d1, v.d0};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // disturb: 1 = extra start mid-run (R7), 2 = u_i change mid-run (R10)
  task automatic run_vec(input vec_t v, input int disturb, input string tag);
    longint mx0, mx1, mu, nx0, nx1, ey0, ey1;
    int cnt;
    bit ep;
    mx0 = sx(v.x0); mx1 = sx(v.x1); mu = sx(v.u);
    fire(v);
    chk(done == 1'b0, "R5 done cleared by restart", done, 0);
    for (int t = 1; t <= int'(v.hz); t++) begin
      cnt = 0;
      while (1) begin
        @(negedge clk);
        cnt++;
        if (t == 1 && cnt == 3 && disturb == 1) begin
          start = 1'b1; x0 = {16'd7777, 16'd9999};
        end
        if (t == 1 && cnt == 3 && disturb == 2) u = 16'd999;
        if (t == 1 && cnt == 4) start = 1'b0;
        if (valid || cnt > 60) break;
      end
      nx0 = rs(sx(v.a00)*mx0 + sx(v.a01)*mx1 + sx(v.b0)*mu);
      nx1 = rs(sx(v.a10)*mx0 + sx(v.a11)*mx1 + sx(v.b1)*mu);
      mx0 = nx0; mx1 = nx1;
      ey0 = rs(sx(v.c00)*mx0 + sx(v.c01)*mx1 + sx(v.d0)*mu);
      ey1 = rs(sx(v.c10)*mx0 + sx(v.c11)*mx1 + sx(v.d1)*mu);
      chk(cnt == STEP_CYC, "R4 step spacing", cnt, STEP_CYC);
      chk(int'(step) == t, "R4 step number", step, t);
      chk(sx(y[15:0]) == ey0, {"R3 y0 ", tag}, sx(y[15:0]), ey0);
      chk(sx(y[31:16]) == ey1, {"R3 y1 ", tag}, sx(y[31:16]), ey1);
      for (int k = 0; k < NP; k++) begin
        ep = pbit(int'((sel[k] ? ey1 : ey0)), int'(thr[k*16 +: 16]), mode[k]);
        chk(prop[k] == ep, "R8 flag", prop[k], ep);
      end
      chk(done == (t == int'(v.hz)), "R5 done with last step", done, (t == int'(v.hz)));
    end
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(done && !valid, "R5 done held, no pulse", {done, valid}, 2);
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R4 watchdog expired actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(step == '0, "R1 step", step, 0);
    chk(y == '0, "R1 y", y, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_vec(VECS[0], 0, "R2");
    run_vec(VECS[1], 1, "R7");
    run_vec(VECS[2], 0, "R9");
    chk(y[15:0] == 16'h7fff && y[31:16] == 16'h7fff, "R9 saturated output", y, 32'h7fff7fff);
    run_vec(VECS[3], 2, "R10");

    // R6: zero horizon
    begin
      vec_t z;
      z = VECS[0];
      z.hz = 8'd0;
      fire(z);
      chk(done == 1'b1, "R6 done next cycle", done, 1);
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        chk(!valid && done, "R6 no pulse", {done, valid}, 2);
      end
    end

    // a normal run after a zero-horizon start
    run_vec(VECS[3], 0, "R2");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule